// File: doc/BRIEF.md
# SPI Transfer Engine with Buffered Data and Status Flags

This block moves 8-bit words over a four-wire serial link in either direction at once, acting as the clock master or as a clocked slave. A CPU-side register port writes outgoing words into a single-entry transmit holding register and collects incoming words from a single-entry receive holding register. A shift register sits between those holding registers and the serial pins, so one word can be queued while the previous one is still on the wire.

As master, the block makes the serial clock from the system clock, with a half period of `divHalf` system cycles. A word starts by itself as soon as transmit data is waiting and the shifter is free. A word queued during a transfer follows after a pause of one bit time. As slave, the block takes the serial clock and select from outside. It resynchronises them and shifts one word per select assertion. A read-only status word reports whether the engine is busy, whether the transmit register can accept data, and whether received data is waiting or has been overwritten.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the status word reads 0x0000_0010 (only transmit-empty set), the receive register reads 0, and `sckOut` is low.
- R2: Register word addresses on `busAddr` are 0 = receive data (read), 1 = transmit data (write), 2 = status (read). In the status word, bit 6 is busy, bit 4 is transmit-empty, bit 3 is receive-overflow and bit 2 is receive-full. Every other bit reads 0.
- R3: In master mode each word is 8 bits, sent MSB first in clock mode 0. `sckOut` idles low, the input is sampled on the rising edge and the output changes on the falling edge. One `sckOut` period is 2*`divHalf` system cycles. A transfer starts without any command once the transmit register holds data.
- R4: In master mode busy is 1 from the start of a transfer to its end. When the transmit register was refilled during a transfer, busy also stays 1 through the one-bit-time gap before the next word and through that word.
- R5: In slave mode busy always reads 0.
- R6: Transmit-empty clears on a write to the transmit register. It sets again when that word is moved into the shift register.
- R7: A write to the transmit register while transmit-empty is 0 is ignored, and the word held there is not changed.
- R8: Receive-full sets when a finished word is loaded into the receive register. It clears when the receive register is read.
- R9: When a word finishes while receive-full is 1, the receive register takes the new word and overflow sets. Overflow clears when the receive register is read.
- R10: When a receive-register read falls in the same cycle as a word finishing, the read returns the previous word. Afterwards receive-full is 1, overflow is 0, and the new word is held.
- R11: In slave mode `ssNIn` and `sckIn` pass through two synchronising flip-flops. A falling select loads the shift register from the transmit register, and loads zeros if that register is empty. Each word is shifted MSB first in mode 0, with `sdiIn` as data in and `sdoOut` as data out.
- R12: Writes to the status address have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| masterMode | input | 1 | 1 = master, 0 = slave; change only while idle |
| divHalf | input | 8 | Master serial-clock half period in system cycles (0 treated as 1) |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 2 | Register word address |
| busWdata | input | 32 | Write data (low 8 bits used for transmit) |
| busRdata | output | 32 | Read data, valid while busSel and busRd are high |
| sckOut | output | 1 | Serial clock driven in master mode |
| sdoOut | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sdiIn | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| sckIn | input | 1 | Serial clock from an external master (slave mode) |
| ssNIn | input | 1 | Active-low slave select (slave mode) |

## Verification
The assertions assume that `masterMode` changes only while the engine is idle. They also assume that a refill of the transmit register during a master transfer is never written in the exact cycle of the final falling edge. The bench therefore switches mode only after polling status to idle, and it refills only after seeing transmit-empty return to 1 early in a word. In slave mode the checks rely on the external clock and select being slow next to the synchroniser delay. The bench keeps every slave-mode clock phase six system cycles long and holds select low for several cycles before the first edge.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  typedef struct packed {
    logic load;
    logic loadZero;
    logic sample;
    logic shift;
    logic done;
  } xferStrobes_t;
endpackage

// File: rtl/spi_xcvr_ctrl.sv
module spi_xcvr_ctrl
  import spi_xcvr_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterMode,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             txEmpty,
  input  logic             sckIn,
  input  logic             ssNIn,
  output xferStrobes_t     stb,
  output logic             sckOut,
  output logic             busy
);
  localparam int CNT_W = DIV_W + 1;
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} ctlState_t;

  ctlState_t        state;
  logic [CNT_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             sckReg;
  logic [1:0]       ssSync, sckSync;
  logic             ssPrev, sckPrev;

  logic [DIV_W-1:0] halfLim;
  logic [CNT_W-1:0] halfEnd, gapEnd;
  logic             ssFall, ssActive, sckRise, sckFall;

  assign halfLim  = (divHalf == '0) ? '0 : divHalf - 1'b1;
  assign halfEnd  = CNT_W'(halfLim);
  assign gapEnd   = {halfLim, 1'b1};
  assign ssActive = ~ssSync[1];
  assign ssFall   = ssPrev & ~ssSync[1];
  assign sckRise  = ~sckPrev & sckSync[1];
  assign sckFall  = sckPrev & ~sckSync[1];

  always_comb begin
    stb = '0;
    if (masterMode) begin
      case (state)
        ST_IDLE:  if (!txEmpty) stb.load = 1'b1;
        ST_SHIFT: if (phaseCnt == halfEnd) begin
                    if (!sckReg) stb.sample = 1'b1;
                    else begin
                      stb.shift = 1'b1;
                      if (bitCnt == LAST_BIT) stb.done = 1'b1;
                    end
                  end
        ST_GAP:   if (phaseCnt == gapEnd) stb.load = 1'b1;
        default:  ;
      endcase
    end else begin
      if (ssFall) begin
        stb.load     = 1'b1;
        stb.loadZero = txEmpty;
      end else if (ssActive) begin
        if (sckRise) stb.sample = 1'b1;
        if (sckFall) begin
          stb.shift = 1'b1;
          if (bitCnt == LAST_BIT) stb.done = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssSync  <= 2'b11;
      ssPrev  <= 1'b1;
      sckSync <= 2'b00;
      sckPrev <= 1'b0;
    end else begin
      ssSync  <= {ssSync[0], ssNIn};
      ssPrev  <= ssSync[1];
      sckSync <= {sckSync[0], sckIn};
      sckPrev <= sckSync[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      sckReg   <= 1'b0;
    end else if (masterMode) begin
      case (state)
        ST_IDLE: if (stb.load) begin
          state    <= ST_SHIFT;
          phaseCnt <= '0;
          bitCnt   <= '0;
          sckReg   <= 1'b0;
        end
        ST_SHIFT: if (phaseCnt == halfEnd) begin
          phaseCnt <= '0;
          sckReg   <= ~sckReg;
          if (stb.done) begin
            bitCnt <= '0;
            state  <= txEmpty ? ST_IDLE : ST_GAP;
          end else if (stb.shift) begin
            bitCnt <= bitCnt + 1'b1;
          end
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
        ST_GAP: if (stb.load) begin
          state    <= ST_SHIFT;
          phaseCnt <= '0;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end else begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      sckReg   <= 1'b0;
      if (ssFall || stb.done) bitCnt <= '0;
      else if (stb.shift)     bitCnt <= bitCnt + 1'b1;
    end
  end

  assign sckOut = sckReg;
  assign busy   = masterMode && (state != ST_IDLE);
endmodule

// File: rtl/spi_xcvr_dp.sv
module spi_xcvr_dp
  import spi_xcvr_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobes_t      stb,
  input  logic              sdiIn,
  input  logic              wrTx,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdRx,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxOvf,
  output logic [WORD_W-1:0] rxData,
  output logic              sdoBit
);
  logic [WORD_W-1:0] txBuf, shiftReg, rxBuf, shiftNext;
  logic              sampleBit;

  assign shiftNext = {shiftReg[WORD_W-2:0], sampleBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf     <= '0;
      txEmpty   <= 1'b1;
      shiftReg  <= '0;
      sampleBit <= 1'b0;
      rxBuf     <= '0;
      rxFull    <= 1'b0;
      rxOvf     <= 1'b0;
    end else begin
      if (wrTx && txEmpty) begin
        txBuf   <= wrData;
        txEmpty <= 1'b0;
      end else if (stb.load && !stb.loadZero) begin
        txEmpty <= 1'b1;
      end

      if (stb.load)       shiftReg <= stb.loadZero ? '0 : txBuf;
      else if (stb.shift) shiftReg <= shiftNext;

      if (stb.sample) sampleBit <= sdiIn;

      if (stb.done) begin
        rxBuf  <= shiftNext;
        rxFull <= 1'b1;
        rxOvf  <= rxFull && !rdRx;
      end else if (rdRx) begin
        rxFull <= 1'b0;
        rxOvf  <= 1'b0;
      end
    end
  end

  assign rxData = rxBuf;
  assign sdoBit = shiftReg[WORD_W-1];
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterMode,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [1:0]       busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             sckOut,
  output logic             sdoOut,
  input  logic             sdiIn,
  input  logic             sckIn,
  input  logic             ssNIn
);
  localparam logic [1:0] ADDR_RX   = 2'd0;
  localparam logic [1:0] ADDR_TX   = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  xferStrobes_t      stb;
  logic              txEmpty, rxFull, rxOvf, busyFlag, wrTx, rdRx;
  logic [WORD_W-1:0] rxData;
  logic [BUS_W-1:0]  statWord;

  assign wrTx = busSel && busWr && (busAddr == ADDR_TX);
  assign rdRx = busSel && busRd && (busAddr == ADDR_RX);

  spi_xcvr_ctrl #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .divHalf(divHalf),
    .txEmpty(txEmpty), .sckIn(sckIn), .ssNIn(ssNIn),
    .stb(stb), .sckOut(sckOut), .busy(busyFlag)
  );

  spi_xcvr_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiIn(sdiIn),
    .wrTx(wrTx), .wrData(busWdata[WORD_W-1:0]), .rdRx(rdRx),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxOvf(rxOvf),
    .rxData(rxData), .sdoBit(sdoOut)
  );

  always_comb begin
    statWord    = '0;
    statWord[6] = busyFlag;
    statWord[4] = txEmpty;
    statWord[3] = rxOvf;
    statWord[2] = rxFull;
  end

  always_comb begin
    busRdata = '0;
    if (busSel && busRd) begin
      case (busAddr)
        ADDR_RX:   busRdata = BUS_W'(rxData);
        ADDR_STAT: busRdata = statWord;
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        masterMode,
  input logic        busyFlag,
  input logic        txEmpty,
  input logic        rxFull,
  input logic        rxOvf,
  input logic        sckOut,
  input logic        busSel,
  input logic        busWr,
  input logic        busRd,
  input logic [1:0]  busAddr,
  input logic [31:0] busRdata
);
  assert_slave_not_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> !busyFlag);

  assert_ovf_implies_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxOvf |-> rxFull);

  assert_sck_low_when_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busyFlag |-> !sckOut);

  assert_tx_write_clears_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 2'd1 && txEmpty) |=> !txEmpty);

  assert_rx_read_clears_ovf_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busRd && busAddr == 2'd0) |=> !rxOvf);

  assert_status_write_keeps_empty_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 2'd2 && !busyFlag && !masterMode) |=> $stable(txEmpty));

  assert_status_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busRd && busAddr == 2'd2) |->
      (busRdata[31:7] == '0 && busRdata[5] == 1'b0 && busRdata[1:0] == 2'b00));
endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode), .busyFlag(busyFlag),
  .txEmpty(txEmpty), .rxFull(rxFull), .rxOvf(rxOvf), .sckOut(sckOut),
  .busSel(busSel), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
  .busRdata(busRdata)
);

// File: tb/spi_xcvr_bench.sv
module spi_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int SH         = 6;

  logic        clk = 1'b0, rstN = 1'b0, masterMode = 1'b1;
  logic [7:0]  divHalf = 8'(HALF);
  logic        busSel = 0, busWr = 0, busRd = 0;
  logic [1:0]  busAddr = 0;
  logic [31:0] busWdata = 0;
  wire  [31:0] busRdata;
  wire         sckOut, sdoOut;
  logic        sdiIn = 0, sckIn = 0, ssNIn = 1;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xcvr u_spi_xcvr (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .divHalf(divHalf),
    .busSel(busSel), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sckOut(sckOut),
    .sdoOut(sdoOut), .sdiIn(sdiIn), .sckIn(sckIn), .ssNIn(ssNIn)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard queues: expected master output words and slave-model reply words
  logic [7:0] expQ[$];
  logic [7:0] misoQ[$];
  logic [7:0] curPat = 0, capBits = 0;
  bit needPat = 1;
  int riseInWord = 0, fallInWord = 0, cyc = 0, lastRise = 0;
  logic sckSeen = 0;

  // monitor / slave model for master mode
  always @(negedge clk) begin
    cyc++;
    if (masterMode && rstN) begin
      if (needPat && misoQ.size() > 0) begin
        curPat  = misoQ.pop_front();
        sdiIn   = curPat[7];
        needPat = 0;
      end
      if (sckOut && !sckSeen) begin
        if (riseInWord > 0) checkEq("R3 sck period", 32'(cyc - lastRise), 32'(2*HALF));
        lastRise = cyc;
        capBits  = {capBits[6:0], sdoOut};
        riseInWord++;
        if (riseInWord == 8) begin
          if (expQ.size() == 0) checkEq("R7 unexpected word", {24'd0, capBits}, 32'hDEAD);
          else checkEq("R3 serial out word", {24'd0, capBits}, {24'd0, expQ.pop_front()});
        end
      end else if (!sckOut && sckSeen) begin
        fallInWord++;
        if (fallInWord == 8) begin
          fallInWord = 0; riseInWord = 0; needPat = 1;
        end else begin
          sdiIn = curPat[7 - fallInWord];
        end
      end
    end
    sckSeen = sckOut;
  end

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busRd = 1; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busSel = 0; busRd = 0;
  endtask

  task automatic waitStatus(input logic [31:0] mask, input logic [31:0] val);
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      busRead(2'd2, s);
      if ((s & mask) == val) return;
    end
    checkEq("poll timeout", s & mask, val);
  endtask

  task automatic sendWord(input logic [7:0] mosi, input logic [7:0] miso);
    expQ.push_back(mosi);
    misoQ.push_back(miso);
    @(negedge clk);
    busWrite(2'd1, {24'd0, mosi});
  endtask

  task automatic slaveXfer(input logic [7:0] mosi, output logic [7:0] miso);
    logic [31:0] s;
    ssNIn = 0;
    repeat (SH) @(negedge clk);
    busRead(2'd2, s);
    checkEq("R5 busy in slave", {31'd0, s[6]}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      sdiIn = mosi[7 - i];
      repeat (SH) @(negedge clk);
      sckIn = 1;
      miso = {miso[6:0], sdoOut};
      repeat (SH) @(negedge clk);
      sckIn = 0;
    end
    repeat (SH) @(negedge clk);
    ssNIn = 1;
    repeat (SH) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    logic [31:0] d;
    logic [7:0] m;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    busRead(2'd2, d); checkEq("R1 reset status", d, 32'h10);
    busRead(2'd0, d); checkEq("R1 reset rx", d, 32'h0);
    checkEq("R1 sck idle", {31'd0, sckOut}, 32'd0);

    // R3/R6/R8 single word
    sendWord(8'hA5, 8'h3C);
    waitStatus(32'h54, 32'h14);
    busRead(2'd2, d); checkEq("R8 full set, R6 empty", d, 32'h14);
    busRead(2'd0, d); checkEq("R8 rx data", d, 32'h3C);
    busRead(2'd2, d); checkEq("R8 full cleared", d, 32'h10);

    // R4/R9 back-to-back with gap, no read between
    sendWord(8'h81, 8'h5A);
    waitStatus(32'h50, 32'h50);
    sendWord(8'h7E, 8'hC3);
    busRead(2'd2, d); checkEq("R4 busy with queued word", d & 32'h50, 32'h40);
    waitStatus(32'h40, 32'h00);
    busRead(2'd2, d); checkEq("R4 busy held through gap, R9 ovf, R2 layout", d, 32'h1C);
    busRead(2'd0, d); checkEq("R9 rx overwritten", d, 32'hC3);
    busRead(2'd2, d); checkEq("R9 ovf cleared by read", d, 32'h10);

    // R7 write while not empty ignored
    sendWord(8'h11, 8'h22);
    waitStatus(32'h50, 32'h50);
    sendWord(8'h33, 8'h44);
    busWrite(2'd1, 32'h99);
    waitStatus(32'h40, 32'h00);
    checkEq("R7 no extra word queued", 32'(expQ.size()), 32'd0);
    repeat (4 * 2 * HALF) @(negedge clk);
    checkEq("R7 ignored word not sent", 32'(expQ.size()), 32'd0);
    busRead(2'd0, d); checkEq("R7 rx last word", d, 32'h44);

    // R10 read in the completion cycle; receive register full beforehand
    sendWord(8'h0F, 8'h66);
    waitStatus(32'h54, 32'h14);
    sendWord(8'hF0, 8'h99);
    wait (riseInWord == 8);
    repeat (HALF - 1) @(negedge clk);
    busSel = 1; busRd = 1; busAddr = 2'd0;
    #1 d = busRdata;
    checkEq("R10 same-cycle read returns old", d, 32'h66);
    @(posedge clk); #1;
    busSel = 0; busRd = 0;
    waitStatus(32'h40, 32'h00);
    busRead(2'd2, d); checkEq("R10 full set ovf clear", d, 32'h14);
    busRead(2'd0, d); checkEq("R10 new word held", d, 32'h99);

    // R12 status write ignored
    busWrite(2'd2, 32'hFFFF_FFFF);
    busRead(2'd2, d); checkEq("R12 status write ignored", d, 32'h10);

    // R11/R5 slave mode
    masterMode = 0;
    @(negedge clk);
    busWrite(2'd1, 32'h96);
    busRead(2'd2, d); checkEq("R5 slave holds data, not busy", d, 32'h00);
    slaveXfer(8'h5A, m);
    checkEq("R11 slave sdo word", {24'd0, m}, 32'h96);
    busRead(2'd2, d); checkEq("R11 slave status", d, 32'h14);
    busRead(2'd0, d); checkEq("R11 slave rx", d, 32'h5A);
    slaveXfer(8'hC3, m);
    checkEq("R11 empty buffer shifts zero", {24'd0, m}, 32'h00);
    busRead(2'd0, d); checkEq("R11 slave rx second", d, 32'hC3);
    busWrite(2'd2, 32'h0);
    busRead(2'd2, d); checkEq("R12 status write ignored in slave", d, 32'h10);

    finish();
  end
endmodule